// File: doc/BRIEF.md
# Ethernet Pause Frame Request Controller

This block decides when a transmit MAC should emit an 802.3x flow-control pause frame, and which quanta value that frame carries. Requests come from one of two places. Software can write a one-shot command into a small register file. Hardware can drive a 2-bit pause vector input. A source-select field chooses which of the two is listened to. A global enable, together with a transmit-path enable input, gates both sources.

Accepted requests wait in a pending stage. From there they are handed to the frame generator through a request/acknowledge handshake that carries an XON/XOFF type and a 16-bit quanta value. After each acknowledged XOFF, a holdoff interval counted in pause quanta keeps the next XOFF from leaving too early. XON is never delayed by this interval. A tick input advances time by a fixed number of bit times per tick, and one quanta is 512 bit times.

Top module: `pause_req_ctrl`

## Requirements
- R1: After reset, the register file reads as follows: command 0, XOFF quanta 0, holdoff 1, control 1 (enable bit 0 = 1, source select bits 2:1 = 00). `pause_req` is low.
- R2: The register map uses these offsets: 0 command (bits 1:0), 1 XOFF quanta (bits 15:0), 2 holdoff (bits 15:0), 3 control (bit 0 enable, bits 2:1 source). All unused bits read as zero and ignore writes. The command register always reads as zero because it clears itself.
- R3: A command write of 01 raises exactly one XON request with quanta 0. A write of 10 raises exactly one XOFF request that carries the programmed quanta. Writes of 00 and 11 raise nothing.
- R4: An XOFF request made while the programmed quanta is 0 is issued as an XON with quanta 0.
- R5: Source select 00 accepts only the vector input. Source select 01 accepts only the command register. Values 10 and 11 accept neither.
- R6: A request that arrives while the enable bit is 0 or `tx_path_en` is low is dropped. It is not issued later.
- R7: The vector input uses the command encoding. A request is taken only when the vector changes to 01 or 10. A held value produces no further requests.
- R8: `pause_req` stays high, with type and quanta unchanged, until `pause_ack` is sampled high. It is low in the following cycle.
- R9: After an XOFF is acknowledged, the next XOFF is not issued until holdoff × 512 / BITS_PER_TICK ticks have been counted. With a tick every cycle, the next XOFF rises exactly holdoff × 8 + 1 cycles after the acknowledge edge (BITS_PER_TICK = 64). Time does not advance without ticks.
- R10: XON is not delayed by the holdoff. When XON and XOFF are both pending, XON is issued first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr` |
| tx_path_en | input | 1 | Transmit path enabled |
| pause_vec | input | 2 | Hardware pause request vector (command encoding) |
| bit_tick | input | 1 | Advances time by BITS_PER_TICK bit times |
| pause_req | output | 1 | Pause frame request to the frame generator |
| pause_is_xoff | output | 1 | 1 = XOFF, 0 = XON |
| pause_quanta | output | 16 | Quanta value to place in the frame |
| pause_ack | input | 1 | Frame generator accepts the request |

## Verification
Several behaviours are checked by the assertions on every cycle. The request holds steady until it is acknowledged and drops right after. An XON always carries zero quanta, and an XOFF never does. An XOFF rises only while the holdoff timer is idle. Unused read-data bits stay zero. Other behaviours can only be shown by the bench's scenarios, because they depend on history and on configuration: source selection, dropping of gated requests, edge detection on the vector, the exact holdoff length in ticks, and XON overtaking a waiting XOFF.

// File: rtl/pause_pkg.sv
// Shared encodings for the pause request controller.
// Assumes a fixed 4-entry register map and 512 bit times per quanta.
package pause_pkg;
    typedef enum logic [1:0] {
        CMD_NONE = 2'b00,
        CMD_XON  = 2'b01,
        CMD_XOFF = 2'b10,
        CMD_RSVD = 2'b11
    } pause_cmd_e;

    typedef enum logic [1:0] {
        SRC_VECTOR = 2'b00,
        SRC_REG    = 2'b01,
        SRC_NONE_A = 2'b10,
        SRC_NONE_B = 2'b11
    } pause_src_e;

    localparam logic [1:0] OFS_CMD    = 2'd0;
    localparam logic [1:0] OFS_QUANTA = 2'd1;
    localparam logic [1:0] OFS_HOLD   = 2'd2;
    localparam logic [1:0] OFS_CTRL   = 2'd3;

    localparam int BITS_PER_QUANTA = 512;
endpackage

// File: rtl/pause_cfg_regs.sv
// Register file for the pause controller.
// Holds the quanta, holdoff and control fields. It turns a write to the
// command offset into a one-cycle strobe (the field clears itself).
// Assumes one write per cycle; reads are combinational.
module pause_cfg_regs
    import pause_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int QW     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [QW-1:0]     xoff_quanta,
    output logic [QW-1:0]     holdoff,
    output logic              enable,
    output pause_src_e        src_sel,
    output logic              cmd_strobe,
    output pause_cmd_e        cmd_code
);
    localparam int PAD_Q = DATA_W - QW;
    localparam int PAD_C = DATA_W - 3;

    // Store the writable fields; the command is not stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xoff_quanta <= '0;
            holdoff     <= QW'(1);
            enable      <= 1'b1;
            src_sel     <= SRC_VECTOR;
        end else if (wr_en) begin
            case (addr)
                OFS_QUANTA: xoff_quanta <= wdata[QW-1:0];
                OFS_HOLD:   holdoff     <= wdata[QW-1:0];
                OFS_CTRL: begin
                    enable  <= wdata[0];
                    src_sel <= pause_src_e'(wdata[2:1]);
                end
                default: ;
            endcase
        end
    end

    // Command strobe is live only in the write cycle.
    always_comb begin
        cmd_strobe = wr_en && (addr == OFS_CMD);
        cmd_code   = pause_cmd_e'(wdata[1:0]);
    end

    // Read mux; unused bits are zero.
    always_comb begin
        case (addr)
            OFS_QUANTA: rdata = {{PAD_Q{1'b0}}, xoff_quanta};
            OFS_HOLD:   rdata = {{PAD_Q{1'b0}}, holdoff};
            OFS_CTRL:   rdata = {{PAD_C{1'b0}}, src_sel, enable};
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/pause_req_src.sv
// Request source selection and qualification.
// Detects changes on the pause vector, picks the source chosen by the
// select field, applies the enable gates, and folds a zero-quanta XOFF
// into an XON. Outputs are single-cycle events.
module pause_req_src
    import pause_pkg::*;
#(
    parameter int QW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          tx_path_en,
    input  pause_src_e    src_sel,
    input  logic          cmd_strobe,
    input  pause_cmd_e    cmd_code,
    input  logic [1:0]    vec_in,
    input  logic [QW-1:0] xoff_quanta,
    output logic          evt_xon,
    output logic          evt_xoff
);
    logic [1:0] vec_prev;
    pause_cmd_e sel_code;
    logic       gate;

    // Remember the last vector value so that only changes count.
    always_ff @(posedge clk) begin
        if (!rst_n) vec_prev <= 2'b00;
        else        vec_prev <= vec_in;
    end

    // Choose the active source's code for this cycle.
    always_comb begin
        sel_code = CMD_NONE;
        case (src_sel)
            SRC_VECTOR: if (vec_in != vec_prev) sel_code = pause_cmd_e'(vec_in);
            SRC_REG:    if (cmd_strobe)         sel_code = cmd_code;
            default:    sel_code = CMD_NONE;
        endcase
    end

    // Gate the event and fold a zero-quanta XOFF into an XON.
    always_comb begin
        gate     = enable && tx_path_en;
        evt_xon  = gate && ((sel_code == CMD_XON) ||
                            ((sel_code == CMD_XOFF) && (xoff_quanta == '0)));
        evt_xoff = gate && (sel_code == CMD_XOFF) && (xoff_quanta != '0);
    end
endmodule

// File: rtl/pause_holdoff.sv
// XOFF holdoff timer.
// Loaded with holdoff * (512 / BITS_PER_TICK) ticks when an XOFF is
// acknowledged, and counted down once per tick. Assumes BITS_PER_TICK
// divides 512.
module pause_holdoff
    import pause_pkg::*;
#(
    parameter int QW            = 16,
    parameter int BITS_PER_TICK = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          load,
    input  logic [QW-1:0] holdoff,
    output logic          idle
);
    localparam int TPQ    = BITS_PER_QUANTA / BITS_PER_TICK;
    localparam int HOLD_W = QW + $clog2(TPQ) + 1;

    logic [HOLD_W-1:0] remain;

    // Load on an XOFF acknowledge, otherwise count down on ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)                      remain <= '0;
        else if (load)                   remain <= HOLD_W'(holdoff) * HOLD_W'(TPQ);
        else if (tick && remain != '0)   remain <= remain - 1'b1;
    end

    // The timer is idle once the count has run out.
    always_comb idle = (remain == '0);
endmodule

// File: rtl/pause_req_ctrl.sv
// Top of the pause frame request controller.
// Keeps the XON/XOFF pending flags, issues one request at a time over a
// req/ack handshake (XON first, XOFF only while the holdoff is idle), and
// starts the holdoff when an XOFF is acknowledged.
module pause_req_ctrl
    import pause_pkg::*;
#(
    parameter int DATA_W        = 32,
    parameter int QW            = 16,
    parameter int BITS_PER_TICK = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [1:0]        cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              tx_path_en,
    input  logic [1:0]        pause_vec,
    input  logic              bit_tick,
    output logic              pause_req,
    output logic              pause_is_xoff,
    output logic [QW-1:0]     pause_quanta,
    input  logic              pause_ack
);
    logic [QW-1:0] xoff_quanta;
    logic [QW-1:0] holdoff;
    logic          enable;
    pause_src_e    src_sel;
    logic          cmd_strobe;
    pause_cmd_e    cmd_code;
    logic          evt_xon;
    logic          evt_xoff;
    logic          hold_idle;
    logic          hold_load;
    logic          xon_pend;
    logic          xoff_pend;
    logic [QW-1:0] xoff_q;

    pause_cfg_regs #(.DATA_W(DATA_W), .QW(QW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .addr(cfg_addr),
        .wdata(cfg_wdata), .rdata(cfg_rdata), .xoff_quanta(xoff_quanta),
        .holdoff(holdoff), .enable(enable), .src_sel(src_sel),
        .cmd_strobe(cmd_strobe), .cmd_code(cmd_code)
    );

    pause_req_src #(.QW(QW)) u_src (
        .clk(clk), .rst_n(rst_n), .enable(enable), .tx_path_en(tx_path_en),
        .src_sel(src_sel), .cmd_strobe(cmd_strobe), .cmd_code(cmd_code),
        .vec_in(pause_vec), .xoff_quanta(xoff_quanta),
        .evt_xon(evt_xon), .evt_xoff(evt_xoff)
    );

    pause_holdoff #(.QW(QW), .BITS_PER_TICK(BITS_PER_TICK)) u_hold (
        .clk(clk), .rst_n(rst_n), .tick(bit_tick), .load(hold_load),
        .holdoff(holdoff), .idle(hold_idle)
    );

    // Holdoff starts on the acknowledge of an XOFF only.
    always_comb hold_load = pause_req && pause_ack && pause_is_xoff;

    // Issue and retire requests, then record new events (new events win).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pause_req     <= 1'b0;
            pause_is_xoff <= 1'b0;
            pause_quanta  <= '0;
            xon_pend      <= 1'b0;
            xoff_pend     <= 1'b0;
            xoff_q        <= '0;
        end else begin
            if (pause_req) begin
                if (pause_ack) pause_req <= 1'b0;
            end else if (xon_pend) begin
                pause_req     <= 1'b1;
                pause_is_xoff <= 1'b0;
                pause_quanta  <= '0;
                xon_pend      <= 1'b0;
            end else if (xoff_pend && hold_idle) begin
                pause_req     <= 1'b1;
                pause_is_xoff <= 1'b1;
                pause_quanta  <= xoff_q;
                xoff_pend     <= 1'b0;
            end
            if (evt_xon) xon_pend <= 1'b1;
            if (evt_xoff) begin
                xoff_pend <= 1'b1;
                xoff_q    <= xoff_quanta;
            end
        end
    end
endmodule

// File: rtl/pause_req_ctrl_chk.sv
// Assertion checker for pause_req_ctrl, attached with bind.
// Watches the handshake, the quanta/type pairing, the holdoff gate and
// the read-data padding.
module pause_req_ctrl_chk #(
    parameter int DATA_W = 32,
    parameter int QW     = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pause_req,
    input logic              pause_ack,
    input logic              pause_is_xoff,
    input logic [QW-1:0]     pause_quanta,
    input logic              hold_idle,
    input logic [DATA_W-1:0] cfg_rdata
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        pause_req && !pause_ack |=> pause_req && $stable(pause_is_xoff) && $stable(pause_quanta)); // R8
    AST_REQ_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        pause_req && pause_ack |=> !pause_req); // R8
    AST_XON_ZERO_QUANTA: assert property (@(posedge clk) disable iff (!rst_n)
        pause_req && !pause_is_xoff |-> pause_quanta == '0); // R3
    AST_XOFF_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        pause_req && pause_is_xoff |-> pause_quanta != '0); // R4
    AST_XOFF_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pause_req) && pause_is_xoff |-> hold_idle); // R9
    AST_RDATA_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[DATA_W-1:QW] == '0); // R2
endmodule

bind pause_req_ctrl pause_req_ctrl_chk #(.DATA_W(DATA_W), .QW(QW)) u_chk (
    .clk(clk), .rst_n(rst_n), .pause_req(pause_req), .pause_ack(pause_ack),
    .pause_is_xoff(pause_is_xoff), .pause_quanta(pause_quanta),
    .hold_idle(hold_idle), .cfg_rdata(cfg_rdata)
);

// File: tb/pause_req_ctrl_test.sv
`timescale 1ns/1ps
module pause_req_ctrl_test;
    localparam real CLKP = 4.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        tx_path_en = 1'b1;
    logic [1:0]  pause_vec = 2'b00;
    logic        bit_tick = 1'b1;
    logic        pause_req;
    logic        pause_is_xoff;
    logic [15:0] pause_quanta;
    logic        pause_ack = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    pause_req_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .tx_path_en(tx_path_en),
        .pause_vec(pause_vec), .bit_tick(bit_tick), .pause_req(pause_req),
        .pause_is_xoff(pause_is_xoff), .pause_quanta(pause_quanta),
        .pause_ack(pause_ack)
    );

    always #(CLKP/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
        step(1);
        cfg_wr_en = 1'b0; cfg_wdata = '0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string tag);
        cfg_addr = a; #0.5;
        chk(cfg_rdata == exp, tag, cfg_rdata, exp);
    endtask

    task automatic wait_req(input int maxc, output int got_at);
        got_at = -1;
        for (int i = 1; i <= maxc; i++) begin
            step(1);
            if (pause_req) begin got_at = i; break; end
        end
    endtask

    task automatic ack();
        pause_ack = 1'b1; step(1); pause_ack = 1'b0;
        chk(!pause_req, "R8 drop after ack", pause_req, 0);
    endtask

    // Expect one request of the given kind (1 xon, 2 xoff) or none (0).
    task automatic expect_req(input int kind, input logic [15:0] q, input string tag);
        int at;
        wait_req(6, at);
        if (kind == 0) begin
            chk(at < 0, tag, at, -1);
        end else begin
            chk(at > 0 && pause_is_xoff == (kind == 2), tag, {pause_req, pause_is_xoff}, {1'b1, kind == 2});
            chk(pause_quanta == ((kind == 2) ? q : 16'h0), tag, pause_quanta, (kind == 2) ? q : 16'h0);
            if (at > 0) ack();
        end
    endtask

    function automatic int exp_kind(input logic [1:0] c, input logic [15:0] q);
        if (c == 2'b01) return 1;
        if (c == 2'b10) return (q == 0) ? 1 : 2;
        return 0;
    endfunction

    initial begin
        #(CLKP * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int at;
        void'($urandom(32'd4242));
        step(3); rst_n = 1'b1; step(1);

        // R1 reset state
        chk(!pause_req, "R1 req low", pause_req, 0);
        rd_chk(2'd0, 32'h0, "R1 cmd");
        rd_chk(2'd1, 32'h0, "R1 quanta");
        rd_chk(2'd2, 32'h1, "R1 holdoff");
        rd_chk(2'd3, 32'h1, "R1 ctrl");

        // R2 unused bits, self-clearing command
        wr(2'd1, 32'hFFFF_FFFF); rd_chk(2'd1, 32'h0000_FFFF, "R2 quanta pad");
        wr(2'd3, 32'hFFFF_FFF8); rd_chk(2'd3, 32'h0, "R2 ctrl pad");
        wr(2'd3, 32'h3); wr(2'd2, 32'h0); wr(2'd1, 32'h1234);
        wr(2'd0, 32'hFFFF_FFFD); rd_chk(2'd0, 32'h0, "R2 cmd clears");
        expect_req(1, 0, "R2 cmd 01 via wide write");

        // R3 register commands
        wr(2'd0, 32'h1); expect_req(1, 0, "R3 xon");
        wr(2'd0, 32'h2); expect_req(2, 16'h1234, "R3 xoff");
        wr(2'd0, 32'h3); expect_req(0, 0, "R3 reserved 11");
        wr(2'd0, 32'h0); expect_req(0, 0, "R3 none 00");

        // R4 zero quanta XOFF becomes XON
        wr(2'd1, 32'h0); wr(2'd0, 32'h2); expect_req(1, 0, "R4 xoff q0");
        wr(2'd1, 32'h00A5);

        // R5 source select
        pause_vec = 2'b10; expect_req(0, 0, "R5 vector ignored in reg mode");
        pause_vec = 2'b00; step(1);
        wr(2'd3, 32'h1);
        wr(2'd0, 32'h2); expect_req(0, 0, "R5 cmd ignored in vector mode");
        pause_vec = 2'b10; expect_req(2, 16'h00A5, "R5 vector xoff");
        wr(2'd3, 32'h5); pause_vec = 2'b01; expect_req(0, 0, "R5 select 10 vector");
        wr(2'd0, 32'h1); expect_req(0, 0, "R5 select 10 cmd");
        wr(2'd3, 32'h7); pause_vec = 2'b10; expect_req(0, 0, "R5 select 11");

        // R7 vector edge detection
        wr(2'd3, 32'h1); pause_vec = 2'b00; step(1);
        pause_vec = 2'b10; expect_req(2, 16'h00A5, "R7 vector rise");
        wait_req(12, at); chk(at < 0, "R7 held level no repeat", at, -1);
        pause_vec = 2'b01; expect_req(1, 0, "R7 vector xon");

        // R6 gating drops requests
        wr(2'd3, 32'h0); pause_vec = 2'b10; expect_req(0, 0, "R6 enable off");
        wr(2'd3, 32'h1); expect_req(0, 0, "R6 dropped not replayed");
        tx_path_en = 1'b0; pause_vec = 2'b01; expect_req(0, 0, "R6 tx path off");
        tx_path_en = 1'b1; expect_req(0, 0, "R6 tx dropped not replayed");

        // R8 request held until ack
        wr(2'd3, 32'h3); wr(2'd0, 32'h2);
        wait_req(6, at); step(5);
        chk(pause_req && pause_is_xoff && pause_quanta == 16'h00A5, "R8 held",
            {pause_req, pause_is_xoff, pause_quanta}, {1'b1, 1'b1, 16'h00A5});
        ack();

        // R9 holdoff gap: 3 quanta, tick every cycle -> 25 cycles
        wr(2'd2, 32'h3); wr(2'd0, 32'h2); wait_req(6, at);
        wr(2'd0, 32'h2);
        ack(); at = 0;
        while (!pause_req && at < 200) begin step(1); at++; end
        chk(at == 25 && pause_is_xoff, "R9 holdoff length", at, 25);
        ack();

        // R10 xon overtakes a waiting xoff
        wr(2'd0, 32'h2); wait_req(40, at); wr(2'd0, 32'h2);
        ack();
        wr(2'd0, 32'h1); wait_req(4, at);
        chk(at > 0 && !pause_is_xoff, "R10 xon first", at, 1);
        ack();
        wait_req(30, at);
        chk(at > 0 && pause_is_xoff, "R10 xoff follows", at, 1);
        ack();

        // R9 no ticks freezes the holdoff
        wr(2'd2, 32'h1); wr(2'd0, 32'h2); wait_req(40, at);
        bit_tick = 1'b0; wr(2'd0, 32'h2); ack();
        wait_req(30, at); chk(at < 0, "R9 frozen without tick", at, -1);
        bit_tick = 1'b1; wait_req(12, at);
        chk(at > 0 && pause_is_xoff, "R9 resumes with tick", at, 1);
        ack();

        // Random register commands with no holdoff
        wr(2'd2, 32'h0);
        for (int i = 0; i < 40; i++) begin
            logic [15:0] q;
            logic [1:0]  c;
            q = ($urandom % 4 == 0) ? 16'h0 : 16'($urandom);
            c = 2'($urandom);
            wr(2'd1, {16'($urandom), q});
            wr(2'd0, {30'($urandom), c});
            expect_req(exp_kind(c, q), q, "R3 random command");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule